// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame should be kept. It watches the six destination address bytes at the head of a frame as they arrive, one per cycle whenever the byte strobe is high. It accumulates the address and a CRC-32 of it on the fly. The cycle after the sixth byte has been taken, it raises a one-cycle decision strobe together with an accept flag.

The decision combines five configuration inputs with a programmed station address and a 64-bit multicast hash table. The configuration inputs are promiscuous, unicast match, broadcast, multicast and multicast hash. The station address comes in as two 24-bit words. The hash table comes in as two 32-bit words. A frame-start pulse marks the first address byte of every frame and restarts any partial address. Bytes after the sixth are ignored until the next frame start.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, and until six address bytes have been taken, `decision_valid_o` and `accept_o` are 0.
- R2: `decision_valid_o` is high for exactly one cycle, namely the cycle after the edge that takes the sixth address byte. `accept_o` is 0 whenever `decision_valid_o` is 0. Bytes strobed after the sixth produce no further decision until the next frame start.
- R3: With `cfg_promisc_i` set, every frame is accepted, whatever the other configuration bits and the hash table hold.
- R4: A frame whose first byte has bit 0 clear is unicast. It is accepted only when `cfg_ucast_i` is 1 and the address equals {`station_hi_i`, `station_lo_i`}. The first received byte corresponds to `station_hi_i[23:16]` and the last to `station_lo_i[7:0]`.
- R5: An all-ones address is broadcast. It is accepted exactly when `cfg_bcast_i` is 1, independent of the multicast and hash settings.
- R6: A non-broadcast frame whose first byte has bit 0 set is multicast. It is rejected when `cfg_mcast_i` is 0. With `cfg_mcast_i` 1 and `cfg_hash_i` 0 it is accepted.
- R7: With `cfg_mcast_i` and `cfg_hash_i` both 1, a multicast frame is accepted exactly when its hash table bit is 1. The index is bits 31:26 of a CRC-32 over the six bytes in arrival order. The CRC uses polynomial 0x04C11DB7 and an initial value of all ones. Each byte is fed least significant bit first, and no final inversion is applied. Index bit 5 picks `hash_hi_i` (1) or `hash_lo_i` (0), and index bits 4:0 pick the bit within that word.
- R8: A byte strobed together with `frame_start_i` is byte 0 of a new frame, even when a previous address was only partly received.
- R9: Cycles with `byte_valid_i` low do not advance the address; gaps between bytes do not change the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Marks the first address byte of a frame |
| byte_valid_i | input | 1 | Address byte strobe |
| byte_i | input | 8 | Address byte |
| cfg_promisc_i | input | 1 | Accept every frame |
| cfg_ucast_i | input | 1 | Accept unicast frames matching the station address |
| cfg_bcast_i | input | 1 | Accept broadcast frames |
| cfg_mcast_i | input | 1 | Accept multicast frames |
| cfg_hash_i | input | 1 | Filter multicast frames through the hash table |
| station_hi_i | input | 24 | Station address, first three bytes |
| station_lo_i | input | 24 | Station address, last three bytes |
| hash_lo_i | input | 32 | Hash table bits for index 0..31 |
| hash_hi_i | input | 32 | Hash table bits for index 32..63 |
| decision_valid_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Frame accepted, qualified by the strobe |

## Verification
Two functions can fall in the same cycle. The decision for one frame is presented in the same cycle in which the frame start and first byte of the next frame are taken. The bench sends frames back to back so that the sixth byte of one frame is followed at once by the first byte of the next. It judges each decision against its own model in the strobe cycle, then checks that the next frame's outcome is unaffected by the overlap. A second collision occurs when a frame start arrives in the middle of a partial address. Here the bench checks that the restarted frame alone decides the result.

// File: rtl/da_filt_pkg.sv
package da_filt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int HALF_W     = ADDR_W / 2;
  localparam int IDX_W      = 6;
  localparam int HREG_W     = 32;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  typedef struct packed {
    logic promisc;
    logic ucast;
    logic bcast;
    logic mcast;
    logic hash;
  } filt_cfg_t;

  // One byte, LSB first, MSB-aligned register, no reflection of the result.
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] crc_in,
                                                input logic [7:0] b);
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[CRC_W-1] ^ b[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction
endpackage

// File: rtl/da_capture.sv
module da_capture
  import da_filt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              take_o,
  output logic              restart_o,
  output logic [ADDR_W-1:0] da_o,
  output logic              done_o
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(ADDR_BYTES - 1);
  localparam logic [CW-1:0] FULL = CW'(ADDR_BYTES);

  logic [CW-1:0]     cnt_q, cnt_eff;
  logic [ADDR_W-1:0] da_q;
  logic              done_q;

  assign cnt_eff   = frame_start_i ? '0 : cnt_q;
  assign take_o    = byte_valid_i && (cnt_eff < FULL);
  assign restart_o = frame_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= FULL;
      da_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= take_o && (cnt_eff == LAST);
      if (take_o) begin
        cnt_q <= cnt_eff + 1'b1;
        da_q  <= {da_q[ADDR_W-9:0], byte_i};
      end else if (frame_start_i) begin
        cnt_q <= '0;
      end
    end
  end

  assign da_o   = da_q;
  assign done_o = done_q;
endmodule

// File: rtl/da_crc_hash.sv
module da_crc_hash
  import da_filt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             take_i,
  input  logic [7:0]       byte_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [CRC_W-1:0] crc_q, crc_base;

  assign crc_base = restart_i ? CRC_INIT : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        crc_q <= CRC_INIT;
    else if (take_i)    crc_q <= crc_byte(crc_base, byte_i);
    else if (restart_i) crc_q <= CRC_INIT;
  end

  assign idx_o = crc_q[CRC_W-1 -: IDX_W];
endmodule

// File: rtl/da_decide.sv
module da_decide
  import da_filt_pkg::*;
(
  input  filt_cfg_t         cfg_i,
  input  logic [ADDR_W-1:0] da_i,
  input  logic [ADDR_W-1:0] station_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [HREG_W-1:0] hash_lo_i,
  input  logic [HREG_W-1:0] hash_hi_i,
  output logic              accept_o
);
  logic is_bcast, is_mcast, hash_hit, mc_ok;
  logic [HREG_W-1:0] hword;

  assign is_bcast = &da_i;
  assign is_mcast = da_i[ADDR_W-8];
  assign hword    = idx_i[IDX_W-1] ? hash_hi_i : hash_lo_i;
  assign hash_hit = hword[idx_i[IDX_W-2:0]];
  assign mc_ok    = cfg_i.mcast && (!cfg_i.hash || hash_hit);

  always_comb begin
    if (cfg_i.promisc)  accept_o = 1'b1;
    else if (is_bcast)  accept_o = cfg_i.bcast;
    else if (is_mcast)  accept_o = mc_ok;
    else                accept_o = cfg_i.ucast && (da_i == station_i);
  end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import da_filt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        frame_start_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  input  logic        cfg_promisc_i,
  input  logic        cfg_ucast_i,
  input  logic        cfg_bcast_i,
  input  logic        cfg_mcast_i,
  input  logic        cfg_hash_i,
  input  logic [23:0] station_hi_i,
  input  logic [23:0] station_lo_i,
  input  logic [31:0] hash_lo_i,
  input  logic [31:0] hash_hi_i,
  output logic        decision_valid_o,
  output logic        accept_o
);
  logic              take, restart, done, dec;
  logic [ADDR_W-1:0] da;
  logic [IDX_W-1:0]  idx;
  filt_cfg_t         cfg;

  assign cfg = '{promisc: cfg_promisc_i, ucast: cfg_ucast_i, bcast: cfg_bcast_i,
                 mcast: cfg_mcast_i, hash: cfg_hash_i};

  da_capture u_capture (
    .clk_i, .rst_ni, .frame_start_i, .byte_valid_i, .byte_i,
    .take_o(take), .restart_o(restart), .da_o(da), .done_o(done)
  );

  da_crc_hash u_crc (
    .clk_i, .rst_ni, .restart_i(restart), .take_i(take), .byte_i, .idx_o(idx)
  );

  da_decide u_decide (
    .cfg_i(cfg), .da_i(da), .station_i({station_hi_i, station_lo_i}),
    .idx_i(idx), .hash_lo_i, .hash_hi_i, .accept_o(dec)
  );

  assign decision_valid_o = done;
  assign accept_o         = done & dec;
endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic byte_valid_i,
  input logic cfg_promisc_i,
  input logic cfg_ucast_i,
  input logic cfg_bcast_i,
  input logic cfg_mcast_i,
  input logic decision_valid_o,
  input logic accept_o
);
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |=> !decision_valid_o); // R2
  AST_ACCEPT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decision_valid_o |-> !accept_o); // R2
  AST_PROMISC_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && cfg_promisc_i) |-> accept_o); // R3
  AST_VALID_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |-> $past(byte_valid_i)); // R9
  AST_ALL_OFF_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && !cfg_promisc_i && !cfg_ucast_i && !cfg_bcast_i && !cfg_mcast_i)
    |-> !accept_o); // R6
endmodule

bind rx_da_filter rx_da_filter_chk u_chk (
  .clk_i, .rst_ni, .byte_valid_i, .cfg_promisc_i, .cfg_ucast_i, .cfg_bcast_i,
  .cfg_mcast_i, .decision_valid_o, .accept_o
);

// File: tb/rx_da_filter_bench.sv
module rx_da_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] ST_HI = 24'h02A1B2;
  localparam logic [23:0] ST_LO = 24'hC3D4E5;

  // {da[47:0], cfg{promisc,ucast,bcast,mcast,hash}, hash_fill, expected}
  localparam int NV = 13;
  localparam logic [54:0] VEC [NV] = '{
    {48'h02A1B2C3D4E5, 5'b01000, 1'b0, 1'b1},  // R4 match
    {48'h02A1B2C3D4E6, 5'b01000, 1'b0, 1'b0},  // R4 mismatch
    {48'h02A1B2C3D4E5, 5'b00000, 1'b0, 1'b0},  // R4 disabled
    {48'hFFFFFFFFFFFF, 5'b00100, 1'b0, 1'b1},  // R5
    {48'hFFFFFFFFFFFF, 5'b00011, 1'b0, 1'b0},  // R5 bcast off
    {48'hFFFFFFFFFFFF, 5'b00111, 1'b0, 1'b1},  // R5 hash ignored
    {48'h01005E000001, 5'b00010, 1'b0, 1'b1},  // R6 no hash
    {48'h01005E000001, 5'b01100, 1'b0, 1'b0},  // R6 mcast off
    {48'h01005E000001, 5'b00011, 1'b1, 1'b1},  // R7 table all ones
    {48'h01005E000001, 5'b00011, 1'b0, 1'b0},  // R7 table empty
    {48'h123456789ABC, 5'b10000, 1'b0, 1'b1},  // R3 unicast
    {48'hFFFFFFFFFFFF, 5'b10000, 1'b0, 1'b1},  // R3 bcast
    {48'h0300AB00CD01, 5'b10011, 1'b0, 1'b1}   // R3 mcast, empty table
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_d = '0;
  logic [4:0] cfg = '0;
  logic [31:0] hlo = '0, hhi = '0;
  logic valid, acc;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_da_filter u_rx_da_filter (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start), .byte_valid_i(byte_valid),
    .byte_i(byte_d), .cfg_promisc_i(cfg[4]), .cfg_ucast_i(cfg[3]), .cfg_bcast_i(cfg[2]),
    .cfg_mcast_i(cfg[1]), .cfg_hash_i(cfg[0]), .station_hi_i(ST_HI), .station_lo_i(ST_LO),
    .hash_lo_i(hlo), .hash_hi_i(hhi), .decision_valid_o(valid), .accept_o(acc)
  );

  function automatic logic [5:0] ref_idx(input logic [47:0] da);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b = da[47 - 8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        logic top = r[31];
        r = r << 1;
        if (top != b[j]) r = r ^ 32'h04C11DB7;
      end
    end
    return r[31:26];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Drives six bytes; optional idle cycle after byte 2. Returns at the negedge
  // following the edge that takes byte 5, where the decision is visible.
  task automatic send(input logic [47:0] da, input bit gap);
    for (int i = 0; i < 6; i++) begin
      if (gap && i == 3) begin
        @(negedge clk); byte_valid = 1'b0; frame_start = 1'b0;
      end
      @(negedge clk);
      frame_start = (i == 0);
      byte_valid  = 1'b1;
      byte_d      = da[47 - 8*i -: 8];
    end
    @(negedge clk);
    frame_start = 1'b0; byte_valid = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !finished) begin
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [5:0] ix;
    logic [47:0] mda;
    repeat (3) @(negedge clk);
    check("R1 valid", valid, 1'b0);
    check("R1 accept", acc, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", valid, 1'b0);

    for (int v = 0; v < NV; v++) begin
      cfg = VEC[v][6:2];
      hlo = {32{VEC[v][1]}};
      hhi = {32{VEC[v][1]}};
      send(VEC[v][54:7], 1'b0);
      check("R2 strobe", valid, 1'b1);
      check($sformatf("R3-table entry %0d", v), acc, VEC[v][0]);
    end

    // R7: only the computed bit set / all but that bit set
    cfg = 5'b00011;
    mda = 48'h3333_0000_00FB;
    ix = ref_idx(mda);
    hlo = '0; hhi = '0;
    if (ix[5]) hhi[ix[4:0]] = 1'b1; else hlo[ix[4:0]] = 1'b1;
    send(mda, 1'b0);
    check("R7 single bit hit", acc, 1'b1);
    hlo = ~hlo; hhi = ~hhi;
    send(mda, 1'b0);
    check("R7 single bit miss", acc, 1'b0);
    mda = 48'h0100_5E7F_FFFA;
    ix = ref_idx(mda);
    hlo = '0; hhi = '0;
    if (ix[5]) hhi[ix[4:0]] = 1'b1; else hlo[ix[4:0]] = 1'b1;
    send(mda, 1'b0);
    check("R7 second address hit", acc, 1'b1);

    // R2: strobe lasts one cycle, trailing bytes ignored
    cfg = 5'b01000;
    send({ST_HI, ST_LO}, 1'b0);
    check("R2 accept", acc, 1'b1);
    byte_valid = 1'b1; byte_d = 8'hAA;
    @(negedge clk);
    check("R2 strobe drops", valid, 1'b0);
    check("R2 accept drops", acc, 1'b0);
    repeat (8) @(negedge clk);
    check("R2 trailing bytes no decision", valid, 1'b0);
    byte_valid = 1'b0;

    // R9: gap inside the address
    send({ST_HI, ST_LO}, 1'b1);
    check("R9 gap strobe", valid, 1'b1);
    check("R9 gap accept", acc, 1'b1);

    // R8: restart mid-address
    @(negedge clk);
    frame_start = 1'b1; byte_valid = 1'b1; byte_d = 8'hFF;
    @(negedge clk);
    frame_start = 1'b0; byte_d = 8'hFF;
    @(negedge clk);
    check("R8 partial no strobe", valid, 1'b0);
    send({ST_HI, ST_LO}, 1'b0);
    check("R8 restart strobe", valid, 1'b1);
    check("R8 restart accept", acc, 1'b1);

    // R8: back-to-back frames; next frame starts in the decision cycle
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      frame_start = (i == 0); byte_valid = 1'b1; byte_d = 8'hFF;
    end
    @(negedge clk);
    check("R8 first of pair strobe", valid, 1'b1);
    check("R8 first of pair reject", acc, 1'b0);
    frame_start = 1'b1; byte_d = ST_HI[23:16];
    for (int i = 1; i < 6; i++) begin
      @(negedge clk);
      frame_start = 1'b0;
      byte_d = {ST_HI, ST_LO}[47 - 8*i -: 8];
      check("R2 no strobe mid frame", valid, 1'b0);
    end
    @(negedge clk);
    byte_valid = 1'b0;
    check("R8 second of pair strobe", valid, 1'b1);
    check("R8 second of pair accept", acc, 1'b1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule